// File: doc/BRIEF.md
# Shadow Fully Associative LRU Tag Directory

This block keeps a tag-only directory that behaves as a fully associative cache with true least-recently-used replacement. It sits next to a set-associative cache and sees the same stream of block accesses. For each access it reports whether the block would have hit in a fully associative cache of the same total capacity. The companion cache combines this flag with its own miss type, so that a miss it takes while the directory hits is a conflict miss and a miss on both sides is a capacity miss.

The directory holds no data and ignores whether an access is a read or a write. Every accepted access updates the recency order. Recency is kept as a per-entry age, where 0 is the most recent entry and ENTRIES-1 is the least recent. The number of entries is the cache size divided by the block size. The address is reduced to its block number before it is compared, so every byte address inside one block selects the same entry.

Top module: `shfa_dir`

## Requirements
- R1: After reset every entry is invalid, entry i holds age i, and both faHit and respValid are 0.
- R2: The compared tag is accAddr shifted right by BLK_LOG2. Two byte addresses inside the same block give the same hit result.
- R3: One cycle after an access, faHit is 1 exactly when a valid entry held that block address.
- R4: On a hit, the matching entry takes age 0. Entries with a smaller age than the hit entry had grow one older. Entries with a larger age keep their age.
- R5: A hit on the entry whose age is already 0 leaves every age unchanged.
- R6: On a miss, the entry with age ENTRIES-1 takes the new tag, becomes valid and takes age 0. Every other entry grows one older.
- R7: The ages of all entries always form a permutation of 0 to ENTRIES-1.
- R8: respValid is 1 for exactly the cycle after each access. Without an access, faHit, the ages and the valid flags keep their values.
- R9: An invalid entry never produces a hit, even when its stored tag equals the looked-up block address.
- R10: Once ENTRIES other distinct blocks have been accessed since a block's last use, that block misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access strobe, one access per cycle |
| accAddr | input | ADDR_W | Byte address of the access |
| faHit | output | 1 | Fully associative hit result, held until the next access |
| respValid | output | 1 | Pulses in the cycle in which faHit carries a new result |
| ageVec | output | ENTRIES*AGE_W | Age of entry i in bits [i*AGE_W +: AGE_W], where 0 is most recent |
| validVec | output | ENTRIES | Valid flag of each entry |

## Verification
The assertions check on every cycle that:
- the ages stay a permutation;
- the block just accessed sits valid at age 0;
- faHit agrees with the stored tags of the previous cycle;
- an empty directory never hits;
- the outputs hold still when there is no access.

Only the bench scenarios can show the exact reordering of hits that fall in the middle of the order, the choice of the victim, hits on the most recent entry that leave the order untouched, and eviction after the capacity is exceeded. These are checked against ages computed by hand for a four-entry directory.

// File: rtl/shfa_pkg.sv
package shfa_pkg;
  typedef struct packed {
    logic update;
    logic isHit;
  } shfaCtlT;
endpackage

// File: rtl/shfa_ctrl.sv
module shfa_ctrl
  import shfa_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accValid,
  input  logic [ENTRIES-1:0] matchVec,
  output shfaCtlT            ctl,
  output logic               faHit,
  output logic               respValid
);
  logic anyMatch;

  assign anyMatch   = |matchVec;
  assign ctl.update = accValid;
  assign ctl.isHit  = accValid && anyMatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faHit     <= 1'b0;
      respValid <= 1'b0;
    end else begin
      respValid <= accValid;
      if (accValid) faHit <= anyMatch;
    end
  end
endmodule

// File: rtl/shfa_datapath.sv
module shfa_datapath
  import shfa_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 27,
  parameter int AGE_W   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  shfaCtlT                    ctl,
  input  logic [TAG_W-1:0]           lookupTag,
  output logic [ENTRIES-1:0]         matchVec,
  output logic [ENTRIES*AGE_W-1:0]   ageVec,
  output logic [ENTRIES-1:0]         validVec,
  output logic [ENTRIES*TAG_W-1:0]   tagVec
);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(ENTRIES - 1);

  logic [TAG_W-1:0] tagQ   [ENTRIES];
  logic [AGE_W-1:0] ageQ   [ENTRIES];
  logic             validQ [ENTRIES];
  logic [AGE_W-1:0] hitAge;
  logic [AGE_W-1:0] pivotAge;

  // age of the matching entry; match is one-hot so an OR-merge suffices
  always_comb begin
    hitAge = '0;
    for (int i = 0; i < ENTRIES; i++)
      hitAge = hitAge | (ageQ[i] & {AGE_W{matchVec[i]}});
  end

  // a miss behaves like a hit on the oldest entry, plus a refill
  assign pivotAge = ctl.isHit ? hitAge : OLDEST;

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    assign matchVec[i] = validQ[i] && (tagQ[i] == lookupTag);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tagQ[i]   <= '0;
        ageQ[i]   <= AGE_W'(i);
        validQ[i] <= 1'b0;
      end else if (ctl.update) begin
        if (ageQ[i] == pivotAge) begin
          ageQ[i] <= '0;
          if (!ctl.isHit) begin
            tagQ[i]   <= lookupTag;
            validQ[i] <= 1'b1;
          end
        end else if (ageQ[i] < pivotAge) begin
          ageQ[i] <= ageQ[i] + 1'b1;
        end
      end
    end

    assign ageVec[i*AGE_W +: AGE_W] = ageQ[i];
    assign tagVec[i*TAG_W +: TAG_W] = tagQ[i];
    assign validVec[i]              = validQ[i];
  end
endmodule

// File: rtl/shfa_dir.sv
module shfa_dir
  import shfa_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BLK_LOG2 = 5,
  parameter int ENTRIES  = 16,
  localparam int TAG_W   = ADDR_W - BLK_LOG2,
  localparam int AGE_W   = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     accValid,
  input  logic [ADDR_W-1:0]        accAddr,
  output logic                     faHit,
  output logic                     respValid,
  output logic [ENTRIES*AGE_W-1:0] ageVec,
  output logic [ENTRIES-1:0]       validVec
);
  shfaCtlT                  ctl;
  logic [ENTRIES-1:0]       matchVec;
  logic [ENTRIES*TAG_W-1:0] tagVec;
  logic [TAG_W-1:0]         lookupTag;

  assign lookupTag = accAddr[ADDR_W-1:BLK_LOG2];

  shfa_ctrl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .matchVec(matchVec),
    .ctl(ctl), .faHit(faHit), .respValid(respValid)
  );

  shfa_datapath #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .AGE_W(AGE_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lookupTag(lookupTag),
    .matchVec(matchVec), .ageVec(ageVec), .validVec(validVec), .tagVec(tagVec)
  );
endmodule

// File: rtl/shfa_dir_chk.sv
module shfa_dir_chk #(
  parameter int ADDR_W   = 32,
  parameter int BLK_LOG2 = 5,
  parameter int ENTRIES  = 16,
  localparam int TAG_W   = ADDR_W - BLK_LOG2,
  localparam int AGE_W   = $clog2(ENTRIES)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     accValid,
  input logic [ADDR_W-1:0]        accAddr,
  input logic                     faHit,
  input logic                     respValid,
  input logic [ENTRIES*AGE_W-1:0] ageVec,
  input logic [ENTRIES-1:0]       validVec,
  input logic [ENTRIES*TAG_W-1:0] tagVec
);
  logic [TAG_W-1:0]   curBlk;
  logic [TAG_W-1:0]   prevBlk;
  logic               curMatch;
  logic               mruHolds;
  logic [ENTRIES-1:0] ageEq [ENTRIES];

  assign curBlk = accAddr[ADDR_W-1:BLK_LOG2];

  always_ff @(posedge clk) begin
    if (!rstN) prevBlk <= '0;
    else if (accValid) prevBlk <= curBlk;
  end

  always_comb begin
    curMatch = 1'b0;
    mruHolds = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (validVec[i] && tagVec[i*TAG_W +: TAG_W] == curBlk) curMatch = 1'b1;
      if (validVec[i] && ageVec[i*AGE_W +: AGE_W] == '0 &&
          tagVec[i*TAG_W +: TAG_W] == prevBlk) mruHolds = 1'b1;
    end
  end

  for (genvar k = 0; k < ENTRIES; k++) begin : gAge
    for (genvar i = 0; i < ENTRIES; i++) begin : gEnt
      assign ageEq[k][i] = (ageVec[i*AGE_W +: AGE_W] == AGE_W'(k));
    end
    a_r7_age_permutation: assert property (@(posedge clk) disable iff (!rstN)
      $countones(ageEq[k]) == 1);
  end

  a_r3_hit_matches_tags: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> faHit == $past(curMatch));

  a_r6_access_lands_mru: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> mruHolds);

  a_r8_resp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> respValid);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !respValid && $stable(faHit) && $stable(ageVec) && $stable(validVec));

  a_r9_empty_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && validVec == '0) |=> !faHit);
endmodule

bind shfa_dir shfa_dir_chk #(.ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2), .ENTRIES(ENTRIES)) uChk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr), .faHit(faHit),
  .respValid(respValid), .ageVec(ageVec), .validVec(validVec), .tagVec(tagVec)
);

// File: tb/sim_shfa_dir.sv
module sim_shfa_dir;
  localparam int ADDR_W = 16;
  localparam int BLKL   = 2;
  localparam int NENT   = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [15:0] accAddr = '0;
  logic        faHit, respValid;
  logic [7:0]  ageVec;
  logic [3:0]  validVec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shfa_dir #(.ADDR_W(ADDR_W), .BLK_LOG2(BLKL), .ENTRIES(NENT)) u0 (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .faHit(faHit), .respValid(respValid), .ageVec(ageVec), .validVec(validVec)
  );

  // {addr[15:0], hit, ages {e3,e2,e1,e0}, valid[3:0]}
  localparam logic [28:0] VEC [11] = '{
    {16'h0000, 1'b0, 8'h39, 4'b1000},  // R9 tag 0 stored invalid: miss
    {16'h0010, 1'b0, 8'h4E, 4'b1100},  // R6
    {16'h0020, 1'b0, 8'h93, 4'b1110},  // R6
    {16'h0013, 1'b1, 8'h87, 4'b1110},  // R2 R4 same block, mid-order hit
    {16'h0030, 1'b0, 8'hD8, 4'b1111},  // R6
    {16'h0001, 1'b1, 8'h2D, 4'b1111},  // R4 hit on oldest
    {16'h0002, 1'b1, 8'h2D, 4'b1111},  // R5 hit on MRU
    {16'h0040, 1'b0, 8'h72, 4'b1111},  // R6 victim is oldest
    {16'h0020, 1'b0, 8'h87, 4'b1111},  // R10 evicted block
    {16'h0010, 1'b0, 8'hD8, 4'b1111},  // R10
    {16'h0000, 1'b1, 8'h2D, 4'b1111}   // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a);
    @(negedge clk);
    accValid = 1'b1;
    accAddr  = a;
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ages", 32'(ageVec), 32'hE4);
    check("R1 valid", 32'(validVec), 32'h0);
    check("R1 hit", 32'(faHit), 32'h0);
    check("R1 resp", 32'(respValid), 32'h0);
    rstN = 1'b1;

    for (int n = 0; n < 11; n++) begin
      access(VEC[n][28:13]);
      check($sformatf("R3 hit step %0d", n), 32'(faHit), 32'(VEC[n][12]));
      check($sformatf("R4/R6 ages step %0d", n), 32'(ageVec), 32'(VEC[n][11:4]));
      check($sformatf("R6 valid step %0d", n), 32'(validVec), 32'(VEC[n][3:0]));
      check($sformatf("R8 resp step %0d", n), 32'(respValid), 32'h1);
    end

    // R8: idle cycles hold state, resp drops
    repeat (3) @(negedge clk);
    check("R8 idle resp", 32'(respValid), 32'h0);
    check("R8 idle hit held", 32'(faHit), 32'h1);
    check("R8 idle ages held", 32'(ageVec), 32'h2D);

    // R1 R9: reset mid-run, then address 0 must miss
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 re-reset ages", 32'(ageVec), 32'hE4);
    check("R1 re-reset hit", 32'(faHit), 32'h0);
    rstN = 1'b1;
    access(16'h0003);
    check("R9 empty miss", 32'(faHit), 32'h0);
    check("R6 first fill ages", 32'(ageVec), 32'h39);

    finish_run();
  end
endmodule